// File: doc/BRIEF.md
# Packet DMA Channel Control Registers

This block is the software-visible register file for a two-channel packet DMA disk engine. A simple memory-mapped bus reaches one register window for each channel and one global byte that unlocks the start function. For each channel the block stores the following values and drives each one straight to the engine core:

- the descriptor count;
- the next-descriptor pointer;
- the two FIFO thresholds;
- the interrupt mask;
- the PIO timing mode.

Writing the start bit produces a one-cycle launch pulse to the core. The block then tracks a busy flag until the core reports completion. Error and completion events from the core are collected into a sticky status byte, which is cleared by reading it. The same events drive a maskable per-channel interrupt.

Software brings a channel back to a known state in two writes. It first writes the control word with the engine-reset bit set, which holds the status and busy state clear. It then writes the control word again with that bit clear, which returns the channel to idle. The stored pointer, count and threshold values are kept through this sequence.

Top module: `pktdma_chan_regs`

## Requirements
- R1: Channel n has a window at byte address 0x80 + 0x20*n. Within the window the registers sit at these offsets: control 0x00, status 0x02, descriptor count 0x04, next-descriptor pointer 0x0C, input threshold 0x14 and output threshold 0x16. The mode-lock byte is at 0xC7 and reads back its stored value. Any other address reads 0.
- R2: The count, pointer and both thresholds are plain read/write registers that drive the matching core outputs. Count and thresholds are 16 bits wide and the pointer is 32 bits wide. All four reset to 0.
- R3: The control word has the following fields:
  - bit 8 is the interrupt mask, resets to 1, and drives eng_irq_mask;
  - bit 5 is the engine reset and drives eng_reset;
  - bits 1:0 are the PIO mode and drive eng_pio_mode.
  Bit 7 always reads back 0, so the control word reads 0x100 after reset.
- R4: A control write with bit 7 = 1 and bit 5 = 0 starts the channel when three conditions hold: the channel is idle, its reset bit is clear, and the mode lock holds 7. A start raises eng_start for exactly the one cycle after the write edge and marks the channel busy.
- R5: A start request is ignored while the channel is busy, and also while the mode lock is not 7. The channel stays busy until core_done is seen.
- R6: The status byte has four sticky flags:
  - bit 0 is set by core_perr;
  - bit 2 is set by core_done while the channel is busy;
  - bit 4 is set by core_uirq;
  - bit 6 is set by core_seqerr.
- R7: A status read returns the current value on bus_rdata one cycle after bus_rd and clears the flags. An event arriving in the same cycle as the read is not lost: it is set after the read.
- R8: chan_irq is 1 when any status flag is set and the mask bit is 0.
- R9: While the reset bit is 1, the status flags and busy are held clear, events are ignored and starts are refused. Count, pointer and thresholds keep their values. Once the bit is cleared, a start is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned to the register width |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| core_done | input | 2 | Per-channel completion event |
| core_perr | input | 2 | Per-channel parity error event |
| core_uirq | input | 2 | Per-channel unexpected interrupt event |
| core_seqerr | input | 2 | Per-channel protocol/sequence fault event |
| eng_start | output | 2 | One-cycle start pulse per channel |
| eng_reset | output | 2 | Engine reset level per channel |
| eng_irq_mask | output | 2 | Interrupt mask per channel |
| eng_pio_mode | output | 4 | PIO mode, 2 bits per channel |
| desc_count | output | 32 | Descriptor count, 16 bits per channel |
| desc_ptr | output | 64 | Next-descriptor pointer, 32 bits per channel |
| fifo_in_thr | output | 32 | Input FIFO threshold, 16 bits per channel |
| fifo_out_thr | output | 32 | Output FIFO threshold, 16 bits per channel |
| chan_irq | output | 2 | Interrupt request per channel |

## Verification
The hardest case to reach from the ports is a core event that lands in the very cycle a status read clears the flags. Getting there requires the event strobe and bus_rd to be raised together on the same falling edge. The stimulus does exactly that, then checks that the read returns the older value and that a second read shows the new flag. A second hard case is busy state that survives a refused start and then an engine reset. It is reached by starting the channel, resetting it without any completion, releasing the reset, and then checking that the next start pulses.

// File: rtl/pktdma_pkg.sv
package pktdma_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;
  localparam int OFS_W  = 5;

  localparam logic [OFS_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [OFS_W-1:0] OFS_STAT = 5'h02;
  localparam logic [OFS_W-1:0] OFS_CNT  = 5'h04;
  localparam logic [OFS_W-1:0] OFS_PTR  = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_FIN  = 5'h14;
  localparam logic [OFS_W-1:0] OFS_FOUT = 5'h16;

  localparam int CB_MASK = 8;
  localparam int CB_GO   = 7;
  localparam int CB_RST  = 5;

  localparam int STAT_W  = 8;
  localparam int SB_PERR = 0;
  localparam int SB_DONE = 2;
  localparam int SB_UIRQ = 4;
  localparam int SB_SEQ  = 6;

  localparam logic [BUS_AW-1:0] LOCK_ADDR = 8'hC7;
  localparam logic [7:0]        LOCK_KEY  = 8'd7;
  localparam int                WIN_BASE  = 'h80;
  localparam int                WIN_SPAN  = 'h20;

  typedef struct packed {
    logic perr;
    logic uirq;
    logic seq;
    logic done;
  } core_ev_t;
endpackage

// File: rtl/pktdma_addr_dec.sv
module pktdma_addr_dec
  import pktdma_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic [BUS_AW-1:0] addr,
  output logic [NUM_CH-1:0] ch_hit,
  output logic              lock_hit,
  output logic [OFS_W-1:0]  ofs
);
  localparam int EXT_W = BUS_AW + 2;

  logic [EXT_W-1:0] addr_x;
  assign addr_x = {2'b00, addr};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_win
    localparam int LO = WIN_BASE + g * WIN_SPAN;
    localparam int HI = LO + WIN_SPAN;
    assign ch_hit[g] = (addr_x >= EXT_W'(LO)) && (addr_x < EXT_W'(HI));
  end

  assign lock_hit = (addr == LOCK_ADDR);
  assign ofs      = addr[OFS_W-1:0];
endmodule

// File: rtl/pktdma_status_unit.sv
module pktdma_status_unit
  import pktdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              rd_clr,
  input  core_ev_t          ev,
  output logic [STAT_W-1:0] stat
);
  logic [STAT_W-1:0] set_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[SB_PERR] = ev.perr;
    set_vec[SB_DONE] = ev.done;
    set_vec[SB_UIRQ] = ev.uirq;
    set_vec[SB_SEQ]  = ev.seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stat <= '0;
    else if (hold)   stat <= '0;
    else if (rd_clr) stat <= set_vec;
    else             stat <= stat | set_vec;
  end

  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_vec == '0) |=> (stat == '0)); // R7
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.uirq && !hold) |=> stat[SB_UIRQ]); // R7
endmodule

// File: rtl/pktdma_chan.sv
module pktdma_chan
  import pktdma_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int THR_W = 16,
  parameter int PTR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [BUS_DW-1:0] wdata,
  input  logic              lock_ok,
  input  logic              core_done,
  input  logic              core_perr,
  input  logic              core_uirq,
  input  logic              core_seqerr,
  output logic [BUS_DW-1:0] rdata_c,
  output logic              start,
  output logic              eng_rst,
  output logic              irq_mask,
  output logic [1:0]        pio,
  output logic [CNT_W-1:0]  cnt,
  output logic [PTR_W-1:0]  ptr,
  output logic [THR_W-1:0]  fin,
  output logic [THR_W-1:0]  fout,
  output logic              irq
);
  logic              busy;
  logic              wr_ctrl;
  logic              go_ok;
  logic              rd_stat;
  logic [STAT_W-1:0] stat;
  core_ev_t          ev;

  assign wr_ctrl = sel && wr && (ofs == OFS_CTRL);
  assign rd_stat = sel && rd && (ofs == OFS_STAT);
  assign go_ok   = wr_ctrl && wdata[CB_GO] && !wdata[CB_RST] && !eng_rst
                   && !busy && lock_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_mask <= 1'b1;
      eng_rst  <= 1'b0;
      pio      <= '0;
      start    <= 1'b0;
      busy     <= 1'b0;
    end else begin
      start <= go_ok;
      if (wr_ctrl) begin
        irq_mask <= wdata[CB_MASK];
        eng_rst  <= wdata[CB_RST];
        pio      <= wdata[1:0];
      end
      if (eng_rst)        busy <= 1'b0;
      else if (go_ok)     busy <= 1'b1;
      else if (core_done) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ptr  <= '0;
      fin  <= '0;
      fout <= '0;
    end else if (sel && wr) begin
      case (ofs)
        OFS_CNT:  cnt  <= wdata[CNT_W-1:0];
        OFS_PTR:  ptr  <= wdata[PTR_W-1:0];
        OFS_FIN:  fin  <= wdata[THR_W-1:0];
        OFS_FOUT: fout <= wdata[THR_W-1:0];
        default: ;
      endcase
    end
  end

  assign ev.perr = core_perr;
  assign ev.uirq = core_uirq;
  assign ev.seq  = core_seqerr;
  assign ev.done = core_done && busy;

  pktdma_status_unit u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (eng_rst),
    .rd_clr (rd_stat),
    .ev     (ev),
    .stat   (stat)
  );

  always_comb begin
    rdata_c = '0;
    case (ofs)
      OFS_CTRL: begin
        rdata_c[CB_MASK] = irq_mask;
        rdata_c[CB_RST]  = eng_rst;
        rdata_c[1:0]     = pio;
      end
      OFS_STAT: rdata_c[STAT_W-1:0] = stat;
      OFS_CNT:  rdata_c[CNT_W-1:0]  = cnt;
      OFS_PTR:  rdata_c[PTR_W-1:0]  = ptr;
      OFS_FIN:  rdata_c[THR_W-1:0]  = fin;
      OFS_FOUT: rdata_c[THR_W-1:0]  = fout;
      default: ;
    endcase
  end

  assign irq = (|stat) && !irq_mask;

  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start); // R4
  AST_GO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ($past(lock_ok) && !$past(busy))); // R5
  AST_RST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |=> (stat == '0)); // R9
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (core_perr && !eng_rst) |=> stat[SB_PERR]); // R6
endmodule

// File: rtl/pktdma_chan_regs.sv
module pktdma_chan_regs
  import pktdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int THR_W  = 16,
  parameter int PTR_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [BUS_AW-1:0]         bus_addr,
  input  logic [BUS_DW-1:0]         bus_wdata,
  output logic [BUS_DW-1:0]         bus_rdata,
  input  logic [NUM_CH-1:0]         core_done,
  input  logic [NUM_CH-1:0]         core_perr,
  input  logic [NUM_CH-1:0]         core_uirq,
  input  logic [NUM_CH-1:0]         core_seqerr,
  output logic [NUM_CH-1:0]         eng_start,
  output logic [NUM_CH-1:0]         eng_reset,
  output logic [NUM_CH-1:0]         eng_irq_mask,
  output logic [2*NUM_CH-1:0]       eng_pio_mode,
  output logic [CNT_W*NUM_CH-1:0]   desc_count,
  output logic [PTR_W*NUM_CH-1:0]   desc_ptr,
  output logic [THR_W*NUM_CH-1:0]   fifo_in_thr,
  output logic [THR_W*NUM_CH-1:0]   fifo_out_thr,
  output logic [NUM_CH-1:0]         chan_irq
);
  logic [NUM_CH-1:0] ch_hit;
  logic              lock_hit;
  logic [OFS_W-1:0]  ofs;
  logic [7:0]        lock_q;
  logic              lock_ok;
  logic [BUS_DW-1:0] ch_rdata [NUM_CH];
  logic [BUS_DW-1:0] rd_mux;

  pktdma_addr_dec #(.NUM_CH(NUM_CH)) u_dec (
    .addr     (bus_addr),
    .ch_hit   (ch_hit),
    .lock_hit (lock_hit),
    .ofs      (ofs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  lock_q <= '0;
    else if (bus_wr && lock_hit) lock_q <= bus_wdata[7:0];
  end
  assign lock_ok = (lock_q == LOCK_KEY);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pktdma_chan #(.CNT_W(CNT_W), .THR_W(THR_W), .PTR_W(PTR_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel         (ch_hit[c]),
      .wr          (bus_wr),
      .rd          (bus_rd),
      .ofs         (ofs),
      .wdata       (bus_wdata),
      .lock_ok     (lock_ok),
      .core_done   (core_done[c]),
      .core_perr   (core_perr[c]),
      .core_uirq   (core_uirq[c]),
      .core_seqerr (core_seqerr[c]),
      .rdata_c     (ch_rdata[c]),
      .start       (eng_start[c]),
      .eng_rst     (eng_reset[c]),
      .irq_mask    (eng_irq_mask[c]),
      .pio         (eng_pio_mode[2*c +: 2]),
      .cnt         (desc_count[CNT_W*c +: CNT_W]),
      .ptr         (desc_ptr[PTR_W*c +: PTR_W]),
      .fin         (fifo_in_thr[THR_W*c +: THR_W]),
      .fout        (fifo_out_thr[THR_W*c +: THR_W]),
      .irq         (chan_irq[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (lock_hit) rd_mux[7:0] = lock_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_hit[c]) rd_mux = rd_mux | ch_rdata[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_hit)); // R1
endmodule

// File: tb/pktdma_chan_regs_tb_top.sv
module pktdma_chan_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NCH-1:0]    core_done = '0, core_perr = '0, core_uirq = '0, core_seqerr = '0;
  logic [NCH-1:0]    eng_start, eng_reset, eng_irq_mask, chan_irq;
  logic [2*NCH-1:0]  eng_pio_mode;
  logic [16*NCH-1:0] desc_count, fifo_in_thr, fifo_out_thr;
  logic [32*NCH-1:0] desc_ptr;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pktdma_chan_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_done(core_done), .core_perr(core_perr), .core_uirq(core_uirq),
    .core_seqerr(core_seqerr), .eng_start(eng_start), .eng_reset(eng_reset),
    .eng_irq_mask(eng_irq_mask), .eng_pio_mode(eng_pio_mode),
    .desc_count(desc_count), .desc_ptr(desc_ptr), .fifo_in_thr(fifo_in_thr),
    .fifo_out_thr(fifo_out_thr), .chan_irq(chan_irq)
  );

  function automatic logic [7:0] ch_base(int ch);
    return 8'(8'h80 + 8'h20 * ch);
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic do_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_done(int ch);
    @(negedge clk); core_done[ch] = 1'b1;
    @(negedge clk); core_done[ch] = 1'b0;
  endtask

  task automatic t_reset_state;
    do_rd(ch_base(0) + 8'h00, rv); chk("R3 ctrl reset value", rv, 32'h100);
    chk("R3 irq mask out", eng_irq_mask, 2'b11);
    do_rd(ch_base(0) + 8'h0C, rv); chk("R2 ptr reset", rv, 0);
    chk("R8 irq idle", chan_irq, 0);
    chk("R2 count out reset", desc_count, 0);
  endtask

  task automatic t_regs;
    do_wr(8'hC7, 32'd7); do_rd(8'hC7, rv); chk("R1 lock readback", rv, 7);
    do_wr(ch_base(0) + 8'h04, 32'd1);
    do_wr(ch_base(0) + 8'h0C, 32'hDEADBEE8);
    do_wr(ch_base(0) + 8'h14, 32'h100);
    do_wr(ch_base(0) + 8'h16, 32'h180);
    do_wr(ch_base(1) + 8'h04, 32'h5);
    do_wr(ch_base(1) + 8'h0C, 32'h12345670);
    do_rd(ch_base(0) + 8'h04, rv); chk("R2 count ch0", rv, 1);
    do_rd(ch_base(0) + 8'h0C, rv); chk("R2 ptr ch0", rv, 32'hDEADBEE8);
    do_rd(ch_base(0) + 8'h14, rv); chk("R2 in thr", rv, 32'h100);
    do_rd(ch_base(0) + 8'h16, rv); chk("R2 out thr", rv, 32'h180);
    chk("R2 ptr outputs", desc_ptr, {32'h12345670, 32'hDEADBEE8});
    chk("R1 count outputs per window", desc_count, {16'h5, 16'h1});
    chk("R2 thr outputs", {fifo_out_thr[15:0], fifo_in_thr[15:0]}, {16'h180, 16'h100});
    do_rd(8'h40, rv); chk("R1 unmapped reads 0", rv, 0);
    do_wr(ch_base(0), 32'h003);
    chk("R3 pio out", eng_pio_mode[1:0], 2'd3);
    chk("R3 mask out cleared", eng_irq_mask[0], 0);
    do_rd(ch_base(0), rv); chk("R3 ctrl readback", rv, 32'h003);
  endtask

  task automatic t_lock_gate;
    do_wr(8'hC7, 32'd0);
    do_wr(ch_base(0), 32'h083);
    chk("R5 no start while unlocked", eng_start, 0);
    do_wr(8'hC7, 32'd7);
  endtask

  task automatic t_start_status;
    do_wr(ch_base(0), 32'h083);
    chk("R4 start pulse", eng_start, 2'b01);
    @(negedge clk); chk("R4 pulse one cycle", eng_start, 0);
    do_rd(ch_base(0), rv); chk("R3 go reads 0", rv, 32'h003);
    do_wr(ch_base(0), 32'h083);
    chk("R5 no start while busy", eng_start, 0);
    pulse_done(0);
    @(negedge clk); chk("R8 irq on done", chan_irq, 2'b01);
    do_rd(ch_base(0) + 8'h02, rv); chk("R6 done flag bit2", rv, 32'h04);
    do_rd(ch_base(0) + 8'h02, rv); chk("R7 cleared by read", rv, 0);
    chk("R8 irq drops", chan_irq, 0);
    do_wr(ch_base(0), 32'h083);
    chk("R4 restart after done", eng_start, 2'b01);
    @(negedge clk); core_seqerr[0] = 1'b1;
    @(negedge clk); core_seqerr[0] = 1'b0;
    do_rd(ch_base(0) + 8'h02, rv); chk("R6 seq flag bit6", rv, 32'h40);
  endtask

  task automatic t_masked;
    do_wr(ch_base(0), 32'h103);
    @(negedge clk); core_perr[0] = 1'b1;
    @(negedge clk); core_perr[0] = 1'b0;
    @(negedge clk); chk("R8 masked irq", chan_irq, 0);
    do_rd(ch_base(0) + 8'h02, rv); chk("R6 parity flag bit0", rv, 32'h01);
    do_wr(ch_base(0), 32'h003);
  endtask

  task automatic t_same_cycle;
    @(negedge clk); core_uirq[0] = 1'b1;
    @(negedge clk); core_uirq[0] = 1'b0;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = ch_base(0) + 8'h02; core_uirq[0] = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; core_uirq[0] = 1'b0;
    chk("R7 read returns older value", bus_rdata, 32'h10);
    do_rd(ch_base(0) + 8'h02, rv); chk("R7 event during read kept", rv, 32'h10);
    do_rd(ch_base(0) + 8'h02, rv); chk("R7 then clear", rv, 0);
  endtask

  task automatic t_chan_reset;
    @(negedge clk); core_perr[0] = 1'b1;
    @(negedge clk); core_perr[0] = 1'b0;
    do_wr(ch_base(0), 32'h023);
    chk("R9 reset out", eng_reset, 2'b01);
    @(negedge clk); core_uirq[0] = 1'b1;
    @(negedge clk); core_uirq[0] = 1'b0;
    do_rd(ch_base(0) + 8'h02, rv); chk("R9 status held clear", rv, 0);
    do_rd(ch_base(0) + 8'h04, rv); chk("R9 count kept", rv, 1);
    do_wr(ch_base(0), 32'h0A3);
    chk("R9 start refused in reset", eng_start, 0);
    do_wr(ch_base(0), 32'h003);
    chk("R9 reset released", eng_reset, 0);
    do_wr(ch_base(0), 32'h083);
    chk("R9 idle after release", eng_start, 2'b01);
    pulse_done(0);
    do_rd(ch_base(0) + 8'h02, rv);
  endtask

  task automatic t_ch1;
    do_wr(ch_base(1), 32'h081);
    chk("R4 ch1 start only", eng_start, 2'b10);
    chk("R1 ch1 pio", eng_pio_mode, 4'b0111);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_lock_gate();
    t_regs();
    t_start_status();
    t_masked();
    t_same_cycle();
    t_chan_reset();
    t_ch1();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule